// File: doc/BRIEF.md
# Byte/Word ALU with Condition-Flag Register

This block is an arithmetic and logic unit with a condition-flag register. It adds, adds with carry, subtracts, subtracts with borrow, increments and decrements. It also forms AND, OR and XOR. Operands are either full words or bytes taken from the low half of each input.

The result is combinational. It is available in the same cycle as the operands. The flag register is a 16-bit word in which nine bits are implemented:

- Six status bits are written from the operation on a clock edge when the update strobe is high.
- Three control bits (trap, interrupt enable, direction) are only stored. Explicit commands set or clear them.

A further command loads every implemented bit at once from a 16-bit input. The unimplemented bits always read a fixed pattern.

A surrounding datapath uses the block as follows. It presents the operands with an operation code and the width bit, and reads the result in the same cycle. It raises the update strobe when the condition flags should be kept. The add-with-carry and subtract-with-borrow operations take their carry-in from the stored carry bit.

Top module: `alu_flagunit`

## Requirements
- R1: While reset is asserted, and on the first edge after it, the flag word reads 0x0002. All implemented bits are 0. Bit 1 reads 1. Bits 3, 5 and 12 to 15 read 0.
- R2: Operation codes 0 (add) and 1 (add with stored carry bit 0 as carry-in) give a result equal to the sum taken modulo 2^W. W is 8 in byte mode (byte_mode=1) and 16 in word mode. Carry (bit 0) is the carry out of bit W-1.
- R3: Operation codes 2 (subtract) and 3 (subtract with stored carry as borrow-in) give the difference modulo 2^W. Carry is set exactly when a borrow into bit W-1 occurs, that is, when the unsigned minuend is smaller than the subtrahend plus borrow.
- R4: The auxiliary bit (bit 4) is set by add, subtract, increment and decrement when the low 4 bits produce a carry out of bit 3 (adds) or take a borrow into bit 3 (subtracts).
- R5: Zero (bit 6) is set exactly when the W-bit result is zero. Sign (bit 7) copies result bit W-1.
- R6: Parity (bit 2) is 1 when the low 8 bits of the result hold an even number of ones, in both modes.
- R7: Overflow (bit 11) is set when the two's-complement result does not fit in W bits.
- R8: Operation codes 4 (AND), 5 (OR) and 6 (XOR) clear carry and overflow, keep the auxiliary bit, and update parity, zero and sign.
- R9: Operation codes 7 (increment A) and 8 (decrement A) keep carry and update the other five status bits.
- R10: The command input takes the following codes: 1/2 set/clear carry, 3/4 set/clear interrupt enable (bit 9), 5/6 set/clear direction (bit 10). Each command touches only its own bit. If a command arrives in the same cycle as a status update, the command wins on its own bit.
- R11: Command 7 writes every implemented bit from the load input and overrides a coincident status update. The unimplemented bits keep their fixed values. The trap bit (bit 8) changes only through this command.
- R12: In byte mode, result bits 15 to 8 are zero. Operation codes 9 to 15 give a zero result and leave the flags unchanged. With the update strobe low and command 0, the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_a | input | 16 | First operand; the only operand used by increment and decrement |
| op_b | input | 16 | Second operand |
| op_code | input | 4 | Operation select, codes 0 to 8 as listed in the requirements |
| byte_mode | input | 1 | 1 = 8-bit operation on the low byte, 0 = 16-bit operation |
| stat_upd_en | input | 1 | Write the status bits from the current operation on the next edge |
| flag_cmd | input | 3 | Flag command: 0 none, 1 to 6 set/clear single bits, 7 full load |
| flag_load | input | 16 | Source word for the full-load command |
| result | output | 16 | Combinational operation result |
| flags | output | 16 | Registered condition and control flag word |

## Verification
The clocked properties take several things for granted. The command input is 0 whenever a status bit is checked against the result, and the operation code is one of the nine defined values. The result port is checked one edge later, against the flags that were written from it. The stored carry is also assumed to be known before a carry-dependent operation. The stimulus keeps to these conditions. Before every sweep step it forces the carry to a chosen value with an explicit command cycle. The bench then issues the operation alone in the next cycle with no command. Commands, loads and undefined codes are exercised only in separate directed phases.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   localparam int FLAG_W = 16;

   // bit positions inside the flag word
   localparam int F_CARRY = 0;
   localparam int F_PAR   = 2;
   localparam int F_AUX   = 4;
   localparam int F_ZERO  = 6;
   localparam int F_SIGN  = 7;
   localparam int F_TRAP  = 8;
   localparam int F_INTR  = 9;
   localparam int F_DIR   = 10;
   localparam int F_OVF   = 11;

   localparam logic [FLAG_W-1:0] IMPL_MASK =
      (FLAG_W'(1) << F_CARRY) | (FLAG_W'(1) << F_PAR) | (FLAG_W'(1) << F_AUX) |
      (FLAG_W'(1) << F_ZERO)  | (FLAG_W'(1) << F_SIGN) | (FLAG_W'(1) << F_TRAP) |
      (FLAG_W'(1) << F_INTR)  | (FLAG_W'(1) << F_DIR)  | (FLAG_W'(1) << F_OVF);

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_AND = 4'd4,
      OP_OR  = 4'd5,
      OP_XOR = 4'd6,
      OP_INC = 4'd7,
      OP_DEC = 4'd8
   } alu_op_e;

   typedef enum logic [2:0] {
      CMD_NONE  = 3'd0,
      CMD_SET_C = 3'd1,
      CMD_CLR_C = 3'd2,
      CMD_SET_I = 3'd3,
      CMD_CLR_I = 3'd4,
      CMD_SET_D = 3'd5,
      CMD_CLR_D = 3'd6,
      CMD_LOAD  = 3'd7
   } flag_cmd_e;

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_flag_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [3:0]        op,
   input  logic              byte_mode,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] stat_val,
   output logic [FLAG_W-1:0] stat_we
);

   localparam int BYTE_W = DATA_W / 2;
   localparam int NIB_W  = BYTE_W / 2;
   localparam int PAR_W  = (BYTE_W < 8) ? BYTE_W : 8;

   localparam logic [FLAG_W-1:0] PZS_MASK =
      (FLAG_W'(1) << F_PAR) | (FLAG_W'(1) << F_ZERO) | (FLAG_W'(1) << F_SIGN);
   localparam logic [FLAG_W-1:0] ARITH_MASK =
      PZS_MASK | (FLAG_W'(1) << F_CARRY) | (FLAG_W'(1) << F_AUX) | (FLAG_W'(1) << F_OVF);
   localparam logic [FLAG_W-1:0] LOGIC_MASK =
      PZS_MASK | (FLAG_W'(1) << F_CARRY) | (FLAG_W'(1) << F_OVF);
   localparam logic [FLAG_W-1:0] STEP_MASK =
      PZS_MASK | (FLAG_W'(1) << F_AUX) | (FLAG_W'(1) << F_OVF);

   alu_op_e             op_e;
   logic                is_sub;
   logic                is_arith;
   logic                is_logic;
   logic                cin_raw;
   logic                cin_eff;
   logic [DATA_W-1:0]   b_sel;
   logic [DATA_W-1:0]   b_eff;
   logic [DATA_W:0]     sum_w;
   logic [BYTE_W:0]     sum_b;
   logic [NIB_W:0]      sum_n;
   logic [DATA_W-1:0]   arith_res;
   logic [DATA_W-1:0]   logic_res;
   logic [DATA_W-1:0]   lane_mask;
   logic                cout;
   logic                a_msb;
   logic                b_msb;
   logic                r_msb;

   assign op_e = alu_op_e'(op);

   always_comb begin
      is_sub   = 1'b0;
      is_arith = 1'b0;
      is_logic = 1'b0;
      cin_raw  = 1'b0;
      b_sel    = b;
      unique case (op_e)
         OP_ADD: is_arith = 1'b1;
         OP_ADC: begin is_arith = 1'b1; cin_raw = carry_in; end
         OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; end
         OP_SBB: begin is_arith = 1'b1; is_sub = 1'b1; cin_raw = carry_in; end
         OP_AND, OP_OR, OP_XOR: is_logic = 1'b1;
         OP_INC: b_sel = DATA_W'(1);
         OP_DEC: begin is_sub = 1'b1; b_sel = DATA_W'(1); end
         default: ;
      endcase
   end

   // subtraction is addition of the inverted operand with inverted borrow
   assign b_eff   = is_sub ? ~b_sel : b_sel;
   assign cin_eff = is_sub ? ~cin_raw : cin_raw;

   assign sum_w = {1'b0, a} + {1'b0, b_eff} + (DATA_W+1)'(cin_eff);
   assign sum_b = {1'b0, a[BYTE_W-1:0]} + {1'b0, b_eff[BYTE_W-1:0]} + (BYTE_W+1)'(cin_eff);
   assign sum_n = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + (NIB_W+1)'(cin_eff);

   assign lane_mask = byte_mode ? {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
   assign arith_res = byte_mode ? {{(DATA_W-BYTE_W){1'b0}}, sum_b[BYTE_W-1:0]}
                                : sum_w[DATA_W-1:0];
   assign cout      = byte_mode ? sum_b[BYTE_W] : sum_w[DATA_W];
   assign a_msb     = byte_mode ? a[BYTE_W-1]     : a[DATA_W-1];
   assign b_msb     = byte_mode ? b_eff[BYTE_W-1] : b_eff[DATA_W-1];

   always_comb begin
      unique case (op_e)
         OP_AND:  logic_res = a & b;
         OP_OR:   logic_res = a | b;
         OP_XOR:  logic_res = a ^ b;
         default: logic_res = '0;
      endcase
   end

   always_comb begin
      if (is_logic)
         result = logic_res & lane_mask;
      else if (is_arith || op_e == OP_INC || op_e == OP_DEC)
         result = arith_res;
      else
         result = '0;
   end

   assign r_msb = byte_mode ? result[BYTE_W-1] : result[DATA_W-1];

   always_comb begin
      stat_val          = '0;
      stat_val[F_CARRY] = is_logic ? 1'b0 : (cout ^ is_sub);
      stat_val[F_AUX]   = sum_n[NIB_W] ^ is_sub;
      stat_val[F_OVF]   = is_logic ? 1'b0 : ((a_msb == b_msb) && (r_msb != a_msb));
      stat_val[F_PAR]   = ~^result[PAR_W-1:0];
      stat_val[F_ZERO]  = ~|result;
      stat_val[F_SIGN]  = r_msb;
      if (is_arith)
         stat_we = ARITH_MASK;
      else if (is_logic)
         stat_we = LOGIC_MASK;
      else if (op_e == OP_INC || op_e == OP_DEC)
         stat_we = STEP_MASK;
      else
         stat_we = '0;
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flag_pkg::*;
#(
   parameter logic [FLAG_W-1:0] RSVD_VAL = 16'h0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [FLAG_W-1:0] stat_val,
   input  logic [FLAG_W-1:0] stat_we,
   input  logic [2:0]        cmd,
   input  logic [FLAG_W-1:0] load_val,
   output logic [FLAG_W-1:0] flags
);

   flag_cmd_e         cmd_e;
   logic [FLAG_W-1:0] set_m;
   logic [FLAG_W-1:0] clr_m;
   logic              do_load;

   assign cmd_e   = flag_cmd_e'(cmd);
   assign do_load = (cmd_e == CMD_LOAD);

   always_comb begin
      set_m = '0;
      clr_m = '0;
      unique case (cmd_e)
         CMD_SET_C: set_m[F_CARRY] = 1'b1;
         CMD_CLR_C: clr_m[F_CARRY] = 1'b1;
         CMD_SET_I: set_m[F_INTR]  = 1'b1;
         CMD_CLR_I: clr_m[F_INTR]  = 1'b1;
         CMD_SET_D: set_m[F_DIR]   = 1'b1;
         CMD_CLR_D: clr_m[F_DIR]   = 1'b1;
         default: ;
      endcase
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_impl
         logic q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= 1'b0;
            else if (do_load)
               q <= load_val[i];
            else if (set_m[i])
               q <= 1'b1;
            else if (clr_m[i])
               q <= 1'b0;
            else if (upd_en && stat_we[i])
               q <= stat_val[i];
         end
         assign flags[i] = q;
      end else begin : g_fixed
         assign flags[i] = RSVD_VAL[i];
      end
   end

   // R10
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_e == CMD_NONE) |=> $stable(flags[F_DIR:F_TRAP]));

   // R11
   full_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_load |=> ((flags & IMPL_MASK) == ($past(load_val) & IMPL_MASK)));

endmodule

// File: rtl/alu_flagunit.sv
module alu_flagunit
   import alu_flag_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter logic [FLAG_W-1:0] RSVD_VAL = 16'h0002
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [3:0]        op_code,
   input  logic              byte_mode,
   input  logic              stat_upd_en,
   input  logic [2:0]        flag_cmd,
   input  logic [FLAG_W-1:0] flag_load,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_W-1:0] flags
);

   localparam int BYTE_W = DATA_W / 2;

   if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_width
      $error("alu_flagunit: DATA_W must be a multiple of 4 and at least 8");
   end

   logic [FLAG_W-1:0] stat_val;
   logic [FLAG_W-1:0] stat_we;

   alu_datapath #(.DATA_W(DATA_W)) u_dp (
      .a         (op_a),
      .b         (op_b),
      .op        (op_code),
      .byte_mode (byte_mode),
      .carry_in  (flags[F_CARRY]),
      .result    (result),
      .stat_val  (stat_val),
      .stat_we   (stat_we)
   );

   alu_flag_reg #(.RSVD_VAL(RSVD_VAL)) u_fr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (stat_upd_en),
      .stat_val (stat_val),
      .stat_we  (stat_we),
      .cmd      (flag_cmd),
      .load_val (flag_load),
      .flags    (flags)
   );

   logic plain_upd;
   assign plain_upd = stat_upd_en && (flag_cmd == 3'd0) && (op_code <= 4'd8);

   // R5
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_upd |=> (flags[F_ZERO] == ($past(result) == '0)));

   // R5
   sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_upd |=> (flags[F_SIGN] ==
         ($past(byte_mode) ? $past(result[BYTE_W-1]) : $past(result[DATA_W-1]))));

   // R6
   parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      plain_upd |=> (flags[F_PAR] == ~^$past(result[7:0])));

   // R8
   logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_upd && op_code >= 4'd4 && op_code <= 4'd6)
      |=> (!flags[F_CARRY] && !flags[F_OVF] && $stable(flags[F_AUX])));

   // R9
   step_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (plain_upd && (op_code == 4'd7 || op_code == 4'd8)) |=> $stable(flags[F_CARRY]));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_upd_en && flag_cmd == 3'd0) |=> $stable(flags));

   // R12
   byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_mode |-> (result[DATA_W-1:BYTE_W] == '0));

endmodule

// File: tb/alu_flagunit_bench.sv
module alu_flagunit_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] op_a, op_b, flag_load;
   logic [3:0]  op_code;
   logic        byte_mode, stat_upd_en;
   logic [2:0]  flag_cmd;
   logic [15:0] result, flags;

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] mflags;

   localparam logic [15:0] IMPL = 16'h0FD5;
   localparam logic [15:0] RSV  = 16'h0002;

   always #2.5 clk = ~clk;

   alu_flagunit u_alu_flagunit (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
      .byte_mode(byte_mode), .stat_upd_en(stat_upd_en), .flag_cmd(flag_cmd),
      .flag_load(flag_load), .result(result), .flags(flags)
   );

   function automatic void model(input int op, input int a, input int b, input bit bm,
                                 input logic [15:0] fin, output int r, output logic [15:0] fo);
      int n, m, am, bv, cv, full, sa, sb, sr;
      bit c, ax, ov, upd_c, upd_a, upd_o, upd_pzs;
      n = bm ? 8 : 16;
      m = (1 << n) - 1;
      am = a & m; bv = b & m; cv = fin[0];
      fo = fin; r = 0;
      c = 0; ax = 0; ov = 0;
      upd_c = 0; upd_a = 0; upd_o = 0; upd_pzs = 0;
      sa = (am >> (n-1)) & 1; sb = (bv >> (n-1)) & 1;
      case (op)
         0, 1: begin
            if (op == 0) cv = 0;
            full = am + bv + cv; r = full & m; sr = (r >> (n-1)) & 1;
            c = ((full >> n) & 1) != 0; ax = ((am & 15) + (bv & 15) + cv) > 15;
            ov = (sa == sb) && (sr != sa);
            upd_c = 1; upd_a = 1; upd_o = 1; upd_pzs = 1;
         end
         2, 3: begin
            if (op == 2) cv = 0;
            full = am - bv - cv; r = full & m; sr = (r >> (n-1)) & 1;
            c = full < 0; ax = ((am & 15) - (bv & 15) - cv) < 0;
            ov = (sa != sb) && (sr != sa);
            upd_c = 1; upd_a = 1; upd_o = 1; upd_pzs = 1;
         end
         4, 5, 6: begin
            r = (op == 4) ? (am & bv) : (op == 5) ? (am | bv) : (am ^ bv);
            upd_c = 1; upd_o = 1; upd_pzs = 1;
         end
         7: begin
            r = (am + 1) & m; ax = ((am & 15) + 1) > 15; ov = (r == (1 << (n-1)));
            upd_a = 1; upd_o = 1; upd_pzs = 1;
         end
         8: begin
            r = (am - 1) & m; ax = (am & 15) == 0; ov = (am == (1 << (n-1)));
            upd_a = 1; upd_o = 1; upd_pzs = 1;
         end
         default: r = 0;
      endcase
      if (upd_c) fo[0] = c;
      if (upd_a) fo[4] = ax;
      if (upd_o) fo[11] = ov;
      if (upd_pzs) begin
         fo[2] = ($countones(r & 255) % 2) == 0;
         fo[6] = (r == 0);
         fo[7] = ((r >> (n-1)) & 1) != 0;
      end
   endfunction

   function automatic string op_tag(input int op);
      if (op <= 1) return "R2";
      if (op <= 3) return "R3";
      if (op <= 6) return "R8";
      if (op <= 8) return "R9";
      return "R12";
   endfunction

   task automatic chk_res(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s result: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic chk_flags(input int op, input string dtag, input logic [15:0] act,
                            input logic [15:0] exp);
      logic [15:0] d;
      string tag;
      n_tests++;
      d = act ^ exp;
      if (d != 16'h0) begin
         n_fail++;
         if (d[0]) tag = (op >= 0) ? op_tag(op) : dtag;
         else if (d[4]) tag = "R4";
         else if (d[6] || d[7]) tag = "R5";
         else if (d[2]) tag = "R6";
         else if (d[11]) tag = "R7";
         else tag = dtag;
         $display("FAIL %s flags: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      op_a = '0; op_b = '0; op_code = 4'd0; byte_mode = 1'b0;
      stat_upd_en = 1'b0; flag_cmd = 3'd0; flag_load = '0;
   endtask

   // one command cycle; expected new flag word given
   task automatic do_cmd(input logic [2:0] c, input logic [15:0] ld,
                         input logic [15:0] exp, input string tag);
      @(negedge clk);
      idle_inputs();
      flag_cmd = c; flag_load = ld;
      @(posedge clk); #1;
      chk_flags(-1, tag, flags, exp);
      mflags = exp;
   endtask

   task automatic run_op(input int op, input int a, input int b, input bit bm, input bit cin);
      int r;
      logic [15:0] fo;
      @(negedge clk);
      idle_inputs();
      flag_cmd = cin ? 3'd1 : 3'd2;
      mflags[0] = cin;
      @(negedge clk);
      flag_cmd = 3'd0; stat_upd_en = 1'b1;
      op_code = op[3:0]; op_a = a[15:0]; op_b = b[15:0]; byte_mode = bm;
      model(op, a, b, bm, mflags, r, fo);
      #1;
      chk_res(op_tag(op), result, r[15:0]);
      @(posedge clk); #1;
      chk_flags(op, "R12", flags, fo);
      mflags = fo;
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int bl[12];
      int wa[8];
      int wb[8];
      int r;
      logic [15:0] fo;
      bl = '{0, 1, 15, 16, 127, 128, 255, 254, 8'h0F, 8'h55, 8'hAA, 8'h81};
      wa = '{16'h7FFF, 16'h8000, 16'hFFFF, 0, 16'h0FFF, 16'h8000, 16'h1234, 16'hFFFF};
      wb = '{1, 1, 1, 0, 1, 16'h8000, 16'h1234, 16'hFFFF};

      idle_inputs();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      // R1 reset state
      chk_flags(-1, "R1", flags, RSV);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk_flags(-1, "R1", flags, RSV);
      mflags = RSV;

      // byte-mode sweep: R2 R3 R4 R5 R6 R7 R8 R9 R12
      for (int a = 0; a < 256; a++)
         for (int j = 0; j < 12; j++)
            for (int op = 0; op < 9; op++)
               run_op(op, a | 16'hA500, bl[j] | 16'h5A00, 1'b1, (a + j) % 2 == 1);

      // word-mode corners and patterns
      for (int i = 0; i < 8; i++)
         for (int op = 0; op < 9; op++) begin
            run_op(op, wa[i], wb[i], 1'b0, 1'b0);
            run_op(op, wa[i], wb[i], 1'b0, 1'b1);
         end
      for (int i = 0; i < 1200; i++)
         for (int op = 0; op < 9; op++)
            run_op(op, (i * 40503 + 7) & 16'hFFFF, ((i * 12345) ^ 16'h5A5A) & 16'hFFFF,
                   1'b0, i % 2 == 1);

      // R10 single-bit commands
      do_cmd(3'd3, 16'h0, mflags | 16'h0200, "R10");
      do_cmd(3'd5, 16'h0, mflags | 16'h0400, "R10");
      do_cmd(3'd1, 16'h0, mflags | 16'h0001, "R10");
      do_cmd(3'd4, 16'h0, mflags & ~16'h0200, "R10");
      do_cmd(3'd6, 16'h0, mflags & ~16'h0400, "R10");
      do_cmd(3'd2, 16'h0, mflags & ~16'h0001, "R10");

      // R10 command wins over coincident update (0xFF+1 byte gives carry 1)
      @(negedge clk);
      idle_inputs();
      op_code = 4'd0; op_a = 16'h00FF; op_b = 16'h0001; byte_mode = 1'b1;
      stat_upd_en = 1'b1; flag_cmd = 3'd2;
      model(0, 16'hFF, 1, 1'b1, mflags, r, fo);
      fo[0] = 1'b0;
      @(posedge clk); #1;
      chk_flags(-1, "R10", flags, fo);
      mflags = fo;

      // R11 full load, coincident with update, overrides it
      @(negedge clk);
      idle_inputs();
      op_code = 4'd0; stat_upd_en = 1'b1; flag_cmd = 3'd7; flag_load = 16'hFFFF;
      @(posedge clk); #1;
      chk_flags(-1, "R11", flags, 16'h0FD7);
      mflags = 16'h0FD7;
      do_cmd(3'd7, 16'h0000, RSV, "R11");
      do_cmd(3'd7, 16'hF12A, (16'hF12A & IMPL) | RSV, "R11");

      // R12 undefined codes: zero result, flags kept
      for (int op = 9; op < 16; op++) run_op(op, 16'hFFFF, 16'h1234, 1'b0, op % 2 == 1);

      // R12 update strobe low: flags kept
      @(negedge clk);
      idle_inputs();
      op_code = 4'd2; op_a = 16'h0000; op_b = 16'h0001;
      @(posedge clk); #1;
      chk_flags(-1, "R12", flags, mflags);

      // R1 reset again from a non-zero state
      do_cmd(3'd7, 16'hFFFF, 16'h0FD7, "R11");
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk); #1;
      chk_flags(-1, "R1", flags, RSV);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule